// File: doc/BRIEF.md
# Two-Speed Angle Combiner Register

This block merges the two angles delivered by a coarse/fine channel pair into one high-resolution shaft angle. On each sample strobe it takes the 16-bit coarse angle, the 16-bit fine angle and a programmed power-of-two speed ratio. It then works out how many whole fine turns lie below the present position. It uses the coarse angle for that estimate and picks the turn count that keeps the fine reading closest to the scaled coarse one. The result is a combined angle of 16 to 24 bits, left-aligned in a 24-bit field.

A host reads the result through a small register read port, with data returned one clock after the request. There are four views:
- the plain coarse angle;
- a 16-bit high half;
- a 16-bit low half;
- a 32-bit wide word.

Reading the low half snapshots the high half, so a later high read always matches the low half just read, however long the host waits. While such a split read is open, new samples are held back and committed once it closes, so the output registers never change between the two halves.

Top module: `angle_pair_combiner`

## Requirements
- R1: After reset every register view reads as zero.
- R2: With ratio code 0 (single speed) the fine angle is ignored and the 24-bit angle is the coarse angle in bits 23:8, with bits 7:0 zero.
- R3: With ratio code k from 1 to 8, the combined angle N has 16+k bits. Its low 16 bits equal the fine angle. Its turn count is the one that minimises the circular distance between N and coarse shifted left by k. The 24-bit angle is N shifted left by 8-k, so every bit below the resolution is zero.
- R4: When the fine angle wraps against the scaled coarse angle, the turn count carries up or borrows down by one, modulo 2^(16+k). This includes the wrap of the whole angle past full scale.
- R5: A ratio code above 8 behaves exactly as code 8.
- R6: Register views by rd_addr:
  - 0 returns the coarse angle in rd_data[15:0];
  - 1 returns angle bits 23:8 in rd_data[15:0];
  - 2 returns angle bits 7:0 in rd_data[15:8], with rd_data[7:0] zero;
  - 3 returns the 24-bit angle in rd_data[31:8], with rd_data[7:0] zero;
  - addresses 4 to 7 return zero.
  Unused upper bits are zero. rd_data is valid in the cycle after rd_en and holds until the next read.
- R7: A read of address 2 captures the high half. A later read of address 1 returns that captured value, and that high read closes the split read.
- R8: A sample strobe that falls in the cycle of a low read, or in any cycle up to and including the closing high read, is deferred. The newest deferred sample is committed at the end of the cycle after the split read closes.
- R9: A sample strobe with no split read open is committed at the clock edge ending its cycle, so a read issued in the next cycle returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Strobe: coarse, fine and ratio are a new sample |
| coarse_ang | input | 16 | Coarse channel angle |
| fine_ang | input | 16 | Fine channel angle |
| ratio_log2 | input | 4 | Speed ratio as a power-of-two exponent |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 3 | Register view select |
| rd_data | output | 32 | Read data, one cycle after rd_en |

## Verification
Two functions can fall in the same cycle: committing a sample and opening or closing a split read. The bench provokes this by raising the sample strobe in the very cycle of a low read, and again in the cycle of the closing high read. It also stacks two strobes inside one open split read. It then judges the outcome from the port alone. The high read must still return the snapshot. A read in the cycle just after the close must return the old angle. The read after that must return only the newest deferred sample.

// File: rtl/angc_pkg.sv
package angc_pkg;
  typedef enum logic [1:0] {
    VIEW_COARSE = 2'd0,
    VIEW_HIGH   = 2'd1,
    VIEW_LOW    = 2'd2,
    VIEW_WIDE   = 2'd3
  } view_e;
endpackage

// File: rtl/angc_merge.sv
module angc_merge #(
  parameter int ANG_W = 16,
  parameter int MAX_K = 8,
  parameter int K_W   = 4,
  localparam int OUT_W = ANG_W + MAX_K
) (
  input  logic [ANG_W-1:0] coarse,
  input  logic [ANG_W-1:0] fine,
  input  logic [K_W-1:0]   k_raw,
  output logic [OUT_W-1:0] ang
);
  logic [K_W-1:0]   k_eff;
  logic [OUT_W-1:0] cand [MAX_K+1];

  assign k_eff = (k_raw > K_W'(MAX_K)) ? K_W'(MAX_K) : k_raw;

  generate
    for (genvar g = 0; g <= MAX_K; g++) begin : g_ratio
      if (g == 0) begin : g_single
        assign cand[g] = OUT_W'(coarse) << MAX_K;
      end else begin : g_multi
        localparam int NW = ANG_W + g;
        logic [NW-1:0]    scaled;
        logic [NW-1:0]    merged;
        logic [ANG_W-1:0] delta;
        assign scaled  = {coarse, {g{1'b0}}};
        assign delta   = fine - scaled[ANG_W-1:0];
        assign merged  = scaled + {{g{delta[ANG_W-1]}}, delta};
        assign cand[g] = OUT_W'(merged) << (MAX_K - g);
      end
    end
  endgenerate

  assign ang = cand[k_eff];
endmodule

// File: rtl/angc_commit.sv
module angc_commit #(
  parameter int ANG_W = 16,
  parameter int MAX_K = 8,
  localparam int OUT_W = ANG_W + MAX_K
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [OUT_W-1:0] ang_in,
  input  logic [ANG_W-1:0] coarse_in,
  input  logic             hold_in,
  input  logic             low_rd,
  output logic [OUT_W-1:0] ang_q,
  output logic [ANG_W-1:0] coarse_q
);
  logic             freeze;
  logic             pend_q, pend_d;
  logic [OUT_W-1:0] pang_q, pang_d, ang_d;
  logic [ANG_W-1:0] pco_q, pco_d, co_d;
  logic             out_en, pend_en;

  assign freeze = hold_in | low_rd;

  always_comb begin
    pend_d  = pend_q;
    pang_d  = pang_q;
    pco_d   = pco_q;
    ang_d   = ang_q;
    co_d    = coarse_q;
    out_en  = 1'b0;
    pend_en = 1'b0;
    if (freeze) begin
      if (smp_valid) begin
        pend_d  = 1'b1;
        pang_d  = ang_in;
        pco_d   = coarse_in;
        pend_en = 1'b1;
      end
    end else if (smp_valid) begin
      ang_d   = ang_in;
      co_d    = coarse_in;
      out_en  = 1'b1;
      pend_d  = 1'b0;
      pend_en = 1'b1;
    end else if (pend_q) begin
      ang_d   = pang_q;
      co_d    = pco_q;
      out_en  = 1'b1;
      pend_d  = 1'b0;
      pend_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ang_q    <= '0;
      coarse_q <= '0;
    end else if (out_en) begin
      ang_q    <= ang_d;
      coarse_q <= co_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pang_q <= '0;
      pco_q  <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
      pang_q <= pang_d;
      pco_q  <= pco_d;
    end
  end

  // R8
  frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(ang_q) && $stable(coarse_q)));

  // R9
  direct_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !freeze) |=> (ang_q == $past(ang_in) && coarse_q == $past(coarse_in)));
endmodule

// File: rtl/angc_regread.sv
module angc_regread
  import angc_pkg::*;
#(
  parameter int ANG_W  = 16,
  parameter int MAX_K  = 8,
  parameter int ADDR_W = 3,
  parameter int RD_W   = 32,
  localparam int OUT_W = ANG_W + MAX_K
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              low_rd,
  input  logic              high_rd,
  input  logic [OUT_W-1:0]  ang_q,
  input  logic [ANG_W-1:0]  coarse_q,
  output logic              hold_q,
  output logic [RD_W-1:0]   rd_data
);
  logic             hold_d;
  logic [ANG_W-1:0] snap_q, snap_d;
  logic [RD_W-1:0]  data_d;
  logic [ANG_W-1:0] high_now;

  assign high_now = ang_q[OUT_W-1 -: ANG_W];

  always_comb begin
    hold_d = hold_q;
    if (low_rd)       hold_d = 1'b1;
    else if (high_rd) hold_d = 1'b0;
    snap_d = low_rd ? high_now : snap_q;
    data_d = '0;
    if (rd_addr < ADDR_W'(4)) begin
      case (view_e'(rd_addr[1:0]))
        VIEW_COARSE: data_d = RD_W'(coarse_q);
        VIEW_HIGH:   data_d = RD_W'(hold_q ? snap_q : high_now);
        VIEW_LOW:    data_d = RD_W'(ang_q[MAX_K-1:0]) << (ANG_W - MAX_K);
        VIEW_WIDE:   data_d = RD_W'(ang_q) << (RD_W - OUT_W);
        default:     data_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      snap_q <= '0;
    end else begin
      hold_q <= hold_d;
      snap_q <= snap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= data_d;
  end

  // R7
  split_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (high_rd && hold_q) |=> (rd_data[ANG_W-1:0] == $past(snap_q)));

  // R6
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr >= ADDR_W'(4)) |=> (rd_data == '0));

  // R6
  low_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_rd |=> (rd_data[ANG_W-MAX_K-1:0] == '0 && rd_data[RD_W-1:ANG_W] == '0));
endmodule

// File: rtl/angle_pair_combiner.sv
module angle_pair_combiner
  import angc_pkg::*;
#(
  parameter int ANG_W  = 16,
  parameter int MAX_K  = 8,
  parameter int K_W    = 4,
  parameter int ADDR_W = 3,
  parameter int RD_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [ANG_W-1:0]  coarse_ang,
  input  logic [ANG_W-1:0]  fine_ang,
  input  logic [K_W-1:0]    ratio_log2,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [RD_W-1:0]   rd_data
);
  localparam int OUT_W = ANG_W + MAX_K;

  logic [1:0]       rst_sync;
  logic             rst_s;
  logic [OUT_W-1:0] ang_new, ang_q;
  logic [ANG_W-1:0] coarse_q;
  logic             hold_q, low_rd, high_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  assign low_rd  = rd_en && (rd_addr == ADDR_W'(VIEW_LOW));
  assign high_rd = rd_en && (rd_addr == ADDR_W'(VIEW_HIGH));

  angc_merge #(.ANG_W(ANG_W), .MAX_K(MAX_K), .K_W(K_W)) u_merge (
    .coarse (coarse_ang),
    .fine   (fine_ang),
    .k_raw  (ratio_log2),
    .ang    (ang_new)
  );

  angc_commit #(.ANG_W(ANG_W), .MAX_K(MAX_K)) u_commit (
    .clk       (clk),
    .rst_n     (rst_s),
    .smp_valid (smp_valid),
    .ang_in    (ang_new),
    .coarse_in (coarse_ang),
    .hold_in   (hold_q),
    .low_rd    (low_rd),
    .ang_q     (ang_q),
    .coarse_q  (coarse_q)
  );

  angc_regread #(.ANG_W(ANG_W), .MAX_K(MAX_K), .ADDR_W(ADDR_W), .RD_W(RD_W)) u_read (
    .clk      (clk),
    .rst_n    (rst_s),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .low_rd   (low_rd),
    .high_rd  (high_rd),
    .ang_q    (ang_q),
    .coarse_q (coarse_q),
    .hold_q   (hold_q),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/angle_pair_combiner_bench.sv
module angle_pair_combiner_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] coarse_ang = '0;
  logic [15:0] fine_ang = '0;
  logic [3:0]  ratio_log2 = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  angle_pair_combiner u_angle_pair_combiner (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .coarse_ang(coarse_ang),
    .fine_ang(fine_ang), .ratio_log2(ratio_log2), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // scoreboard queues
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // bench model of the register state
  logic [23:0] m_ang = '0, b_ang = '0;
  logic [15:0] m_co = '0, b_co = '0, m_snap = '0;
  bit          m_hold = 1'b0, b_v = 1'b0;

  function automatic logic [23:0] ref_angle(input logic [15:0] co, input logic [15:0] fi,
                                            input logic [3:0] kr);
    int k;
    longint md, c, c0, best_n, best_d;
    k = (kr > 4'd8) ? 8 : int'(kr);
    if (k == 0) return {co, 8'h00};
    md = longint'(1) << (16 + k);
    c  = longint'(co) << k;
    c0 = c >> 16;
    best_n = 0;
    best_d = md;
    for (int j = -1; j <= 1; j++) begin
      longint n, d, cd;
      n  = (((c0 + j) * 65536 + longint'(fi)) % md + md) % md;
      d  = ((n - c) % md + md) % md;
      cd = (d < md - d) ? d : md - d;
      if (cd < best_d) begin
        best_d = cd;
        best_n = n;
      end
    end
    return 24'(best_n << (8 - k));
  endfunction

  task automatic step(input bit s, input logic [15:0] co, input logic [15:0] fi,
                      input logic [3:0] kr, input bit r, input logic [2:0] ad,
                      input string tag);
    bit lo, hi, frz;
    logic [23:0] na;
    smp_valid  = s;
    coarse_ang = co;
    fine_ang   = fi;
    ratio_log2 = kr;
    rd_en      = r;
    rd_addr    = ad;
    if (r) begin
      logic [31:0] e;
      case (ad)
        3'd0:    e = {16'h0, m_co};
        3'd1:    e = {16'h0, m_hold ? m_snap : m_ang[23:8]};
        3'd2:    e = {16'h0, m_ang[7:0], 8'h00};
        3'd3:    e = {m_ang, 8'h00};
        default: e = 32'h0;
      endcase
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    lo  = r && ad == 3'd2;
    hi  = r && ad == 3'd1;
    frz = m_hold || lo;
    na  = ref_angle(co, fi, kr);
    if (lo) m_snap = m_ang[23:8];
    if (s && frz) begin
      b_v = 1'b1; b_ang = na; b_co = co;
    end else if (!frz) begin
      if (s) begin
        m_ang = na; m_co = co; b_v = 1'b0;
      end else if (b_v) begin
        m_ang = b_ang; m_co = b_co; b_v = 1'b0;
      end
    end
    if (lo)      m_hold = 1'b1;
    else if (hi) m_hold = 1'b0;
    @(negedge clk);
    smp_valid = 1'b0;
    rd_en     = 1'b0;
  endtask

  task automatic sample(input logic [15:0] co, input logic [15:0] fi, input logic [3:0] kr);
    step(1'b1, co, fi, kr, 1'b0, 3'd0, "");
  endtask

  task automatic rd(input logic [2:0] ad, input string tag);
    step(1'b0, 16'h0, 16'h0, 4'd0, 1'b1, ad, tag);
  endtask

  task automatic read_all(input string tag);
    rd(3'd0, tag);
    rd(3'd2, tag);
    rd(3'd1, tag);
    rd(3'd3, tag);
  endtask

  // monitor
  bit rd_pend = 1'b0;
  always @(posedge clk) rd_pend <= rd_en;
  always @(negedge clk) begin
    if (rd_pend) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R-watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset values
    read_all("R1");
    // R2 single speed, fine ignored
    sample(16'h1234, 16'hBEEF, 4'd0); read_all("R2");
    // R3 ratio 16 and ratio 8 with zeroed low bits
    sample(16'h0800, 16'h00E3, 4'd4); read_all("R3");
    sample(16'hABCD, 16'h1357, 4'd3); read_all("R3_k3");
    // R4 carry, borrow, full-scale wrap
    sample(16'h12FF, 16'h0010, 4'd8); read_all("R4_carry");
    sample(16'h1301, 16'hFFF0, 4'd8); read_all("R4_borrow");
    sample(16'hFFFF, 16'h0020, 4'd8); read_all("R4_fullwrap");
    // R5 clamp of ratio code
    sample(16'h4567, 16'h6789, 4'd12); read_all("R5");
    // R6 unmapped view
    rd(3'd5, "R6"); rd(3'd7, "R6");
    // R7 snapshot survives a long gap and a new sample
    sample(16'h2222, 16'h3333, 4'd2);
    rd(3'd2, "R7");
    sample(16'h9999, 16'h0101, 4'd2);
    repeat (5) step(1'b0, 16'h0, 16'h0, 4'd0, 1'b0, 3'd0, "");
    rd(3'd1, "R7");
    rd(3'd1, "R8_after_close");
    read_all("R8_committed");
    // R8 strobe in the same cycle as the low read and as the high read, newest wins
    step(1'b1, 16'h0F0F, 16'hF0F0, 4'd6, 1'b1, 3'd2, "R8_same_low");
    step(1'b1, 16'h7070, 16'h1234, 4'd6, 1'b0, 3'd0, "");
    step(1'b1, 16'h5A5A, 16'hA5A5, 4'd5, 1'b1, 3'd1, "R8_same_high");
    rd(3'd3, "R8_gap");
    read_all("R8_newest");
    // R9 back-to-back sample then read
    sample(16'h0001, 16'h8001, 4'd1); rd(3'd3, "R9");
    sample(16'hFFFE, 16'h0003, 4'd7); rd(3'd3, "R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule